// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-facing protocol engine of a serial EEPROM that answers on a two-wire clock/data bus. Both bus lines are brought into the system clock domain. From them the engine finds the bus framing conditions and walks each transfer byte by byte. It acknowledges a transfer only when the leading byte carries the device's fixed identity code. It keeps an 11-bit word pointer that survives from one transaction to the next.

Write traffic leaves the engine on a byte port that feeds a page buffer. When a write transaction is closed, a single commit strobe starts the self-timed programming cycle. Read traffic pulls bytes from a synchronous memory array with one cycle of read latency. The engine does not drive the data line itself. It raises an open-drain pull-down enable, which is used both for acknowledge bits and for read data bits. While the write sequencer reports that a program cycle is running, the engine acknowledges no one, so a host can poll for completion by acknowledge.

Top module: `ee2w_slave`

## Requirements
- R1: A falling data line while the clock is high is a START, and a rising data line while the clock is high is a STOP. After reset and after any STOP the engine is idle and `sda_oe` is 0.
- R2: The first byte after a START is acknowledged only if its upper nibble (bits 7:4) is 1010. Any other value is not acknowledged, and every later clock is ignored until the next START or STOP.
- R3: While `wr_busy_i` is 1 at the end of the first byte, that byte gets no acknowledge. Once `wr_busy_i` is 0, the same byte is acknowledged.
- R4: In a write (first byte bit 0 = 0), bits 3:1 of the first byte and the whole second byte form the pointer {bits 3:1, second byte}. Each later byte is acknowledged and shown on `pb_wr_en`/`pb_wr_addr`/`pb_wr_data` at the current pointer.
- R5: After each write data byte, only the low 4 pointer bits step by one. They wrap inside the 16-byte page, and the upper 7 bits stay fixed.
- R6: `pb_commit` pulses for one cycle at a STOP only if the transaction accepted at least one data byte. A repeated START before the STOP cancels the commit but keeps the pointer.
- R7: A write first byte plus a word address, followed by a repeated START and a read first byte (bit 0 = 1), returns the byte at that address.
- R8: A read that follows its first byte directly returns the byte at the pointer. The pointer is always one past the last byte read or written.
- R9: When the master acknowledges a read byte, the engine sends the next byte. The pointer steps by one over all 11 bits, so after 2047 it goes to 0.
- R10: When the master does not acknowledge a read byte, the engine releases the data line. It then drives nothing and fetches nothing until a START or STOP.
- R11: A START that arrives partway through a byte abandons that byte. The byte that follows is decoded as a fresh first byte.
- R12: `sda_oe` changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| sda_oe | output | 1 | 1 pulls the data line low |
| wr_busy_i | input | 1 | Program cycle in progress |
| pb_wr_en | output | 1 | One-cycle strobe: a write data byte was received |
| pb_wr_addr | output | 11 | Array address of that byte |
| pb_wr_data | output | 8 | The received byte |
| pb_commit | output | 1 | One-cycle strobe: start programming the page |
| mem_rd_en | output | 1 | Array read request |
| mem_rd_addr | output | 11 | Array read address |
| mem_rd_data | input | 8 | Array data, valid the cycle after the request |

## Verification
The bench goes after the page-boundary wrap of a 16-byte-plus write. A design that let the carry reach the upper pointer bits would scatter the trailing bytes into the next page. It also probes the top of the address space during a sequential read, where a pointer that does not wrap would return garbage. A further target is the cancelled write: data bytes followed by a repeated START, where a careless engine would program anyway. Acknowledge polling, a START inside a byte, and a master that declines a read byte are each driven until the engine's reply shows whether it dropped the stale state or kept talking over the bus.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_WAIT
    } eng_st_e;

    typedef enum logic [1:0] {
        BK_CTRL,
        BK_ADDR,
        BK_DATA
    } byte_kind_e;

endpackage

// File: rtl/ee2w_cdc.sv
module ee2w_cdc #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/ee2w_busdet.sv
module ee2w_busdet (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    // framing conditions: data moves while clock stays high
    assign scl_rise  =  scl_s && !prev_q.scl;
    assign scl_fall  = !scl_s &&  prev_q.scl;
    assign start_det =  scl_s &&  prev_q.scl &&  prev_q.sda && !sda_s;
    assign stop_det  =  scl_s &&  prev_q.scl && !prev_q.sda &&  sda_s;
endmodule

// File: rtl/ee2w_ptr.sv
module ee2w_ptr #(
    parameter int AW     = 11,
    parameter int PAGE_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          inc_page,
    input  logic          inc_lin,
    output logic [AW-1:0] ptr_q
);
    logic [AW-1:0] ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        if (ld) begin
            ptr_d = ld_val;
        end else if (inc_page) begin
            // carry stays inside the page
            ptr_d = {ptr_q[AW-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
        end else if (inc_lin) begin
            ptr_d = ptr_q + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
    import ee2w_pkg::*;
#(
    parameter int         AW          = 11,
    parameter int         BLK_W       = 3,
    parameter int         PAGE_W      = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b1010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic          wr_busy_i,
    output logic          pb_wr_en,
    output logic [AW-1:0] pb_wr_addr,
    output logic [7:0]    pb_wr_data,
    output logic          pb_commit,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [7:0]    mem_rd_data
);
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 4;
    localparam int N_LINES  = 2;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_LOW  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_HIGH = CNT_W'(BYTE_W + 1);

    // ---------------- synchronizers ----------------
    logic [N_LINES-1:0] raw_lines, sync_lines;
    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        ee2w_cdc #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cdc (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_lines[g]),
            .q     (sync_lines[g])
        );
    end

    logic scl_s, sda_s;
    assign scl_s = sync_lines[1];
    assign sda_s = sync_lines[0];

    logic scl_rise, scl_fall, start_det, stop_det;

    ee2w_busdet u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // ---------------- pointer ----------------
    logic          ptr_ld, ptr_pg_inc, ptr_lin_inc;
    logic [AW-1:0] ptr_ld_val, ptr_q;

    ee2w_ptr #(.AW(AW), .PAGE_W(PAGE_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (ptr_ld),
        .ld_val   (ptr_ld_val),
        .inc_page (ptr_pg_inc),
        .inc_lin  (ptr_lin_inc),
        .ptr_q    (ptr_q)
    );

    // ---------------- engine state ----------------
    typedef struct packed {
        eng_st_e         st;
        byte_kind_e      kind;
        logic [CNT_W-1:0] cnt;
        logic [BYTE_W-1:0] sr;
        logic            oe;
        logic            nxt_tx;
        logic            ld;
        logic            wrote;
        logic [BLK_W-1:0] blk;
        logic            commit;
        logic            wr_en;
        logic [AW-1:0]   wr_addr;
        logic [BYTE_W-1:0] wr_data;
        logic            rd_en;
        logic [AW-1:0]   rd_addr;
    } eng_r_t;

    localparam eng_r_t ENG_RST = '{st: ST_IDLE, kind: BK_CTRL, default: '0};

    eng_r_t r_d, r_q;
    logic [BYTE_W-1:0] byte_in;
    assign byte_in = {r_q.sr[BYTE_W-2:0], sda_s};

    always_comb begin
        r_d         = r_q;
        r_d.wr_en   = 1'b0;
        r_d.commit  = 1'b0;
        r_d.rd_en   = 1'b0;
        r_d.ld      = r_q.rd_en;
        ptr_ld      = 1'b0;
        ptr_ld_val  = ptr_q;
        ptr_pg_inc  = 1'b0;
        ptr_lin_inc = 1'b0;

        // fetched byte lands one cycle after the array request
        if (r_q.ld) r_d.sr = mem_rd_data;

        if (start_det) begin
            r_d.st    = ST_RX;
            r_d.kind  = BK_CTRL;
            r_d.cnt   = '0;
            r_d.oe    = 1'b0;
            r_d.wrote = 1'b0;
        end else if (stop_det) begin
            r_d.st     = ST_IDLE;
            r_d.oe     = 1'b0;
            r_d.commit = r_q.wrote;
            r_d.wrote  = 1'b0;
        end else begin
            case (r_q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        r_d.sr  = byte_in;
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.cnt    = ACK_LOW;
                            r_d.nxt_tx = 1'b0;
                            case (r_q.kind)
                                BK_CTRL: begin
                                    if (byte_in[7:4] == DEV_CODE && !wr_busy_i) begin
                                        r_d.st     = ST_ACK;
                                        r_d.nxt_tx = byte_in[0];
                                        r_d.kind   = BK_ADDR;
                                        if (!byte_in[0]) r_d.blk = byte_in[BLK_W:1];
                                    end else begin
                                        r_d.st = ST_WAIT;
                                    end
                                end
                                BK_ADDR: begin
                                    ptr_ld     = 1'b1;
                                    ptr_ld_val = {r_q.blk, byte_in};
                                    r_d.kind   = BK_DATA;
                                    r_d.st     = ST_ACK;
                                end
                                default: begin
                                    r_d.wr_en   = 1'b1;
                                    r_d.wr_addr = ptr_q;
                                    r_d.wr_data = byte_in;
                                    r_d.wrote   = 1'b1;
                                    ptr_pg_inc  = 1'b1;
                                    r_d.st      = ST_ACK;
                                end
                            endcase
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (r_q.cnt == ACK_LOW) begin
                            r_d.oe = 1'b1;
                        end else if (r_q.nxt_tx) begin
                            r_d.st  = ST_TX;
                            r_d.cnt = '0;
                            r_d.oe  = ~r_q.sr[BYTE_W-1];
                        end else begin
                            r_d.st  = ST_RX;
                            r_d.cnt = '0;
                            r_d.oe  = 1'b0;
                        end
                    end else if (scl_rise && r_q.cnt == ACK_LOW) begin
                        r_d.cnt = ACK_HIGH;
                        if (r_q.nxt_tx) begin
                            r_d.rd_en   = 1'b1;
                            r_d.rd_addr = ptr_q;
                            ptr_lin_inc = 1'b1;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end else if (scl_fall) begin
                        if (r_q.cnt == ACK_LOW) begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_RACK;
                        end else begin
                            r_d.sr = {r_q.sr[BYTE_W-2:0], 1'b0};
                            r_d.oe = ~r_q.sr[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (!sda_s) begin
                            r_d.rd_en   = 1'b1;
                            r_d.rd_addr = ptr_q;
                            ptr_lin_inc = 1'b1;
                            r_d.nxt_tx  = 1'b1;
                            r_d.cnt     = ACK_HIGH;
                            r_d.st      = ST_ACK;
                        end else begin
                            r_d.st = ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= ENG_RST;
        else        r_q <= r_d;
    end

    eng_st_e st_mon;
    assign st_mon = r_q.st;

    assign sda_oe      = r_q.oe;
    assign pb_wr_en    = r_q.wr_en;
    assign pb_wr_addr  = r_q.wr_addr;
    assign pb_wr_data  = r_q.wr_data;
    assign pb_commit   = r_q.commit;
    assign mem_rd_en   = r_q.rd_en;
    assign mem_rd_addr = r_q.rd_addr;
endmodule

// File: rtl/ee2w_chk.sv
module ee2w_chk
    import ee2w_pkg::*;
#(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          stop_det,
    input logic          sda_oe,
    input eng_st_e       st,
    input logic          pb_commit,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_rd_addr,
    input logic [AW-1:0] ptr
);
    a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && st == ST_IDLE));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_WAIT) |-> !sda_oe);

    a_r6_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pb_commit |=> !pb_commit);

    a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (ptr == AW'(mem_rd_addr + AW'(1))));

    a_r12_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);
endmodule

bind ee2w_slave ee2w_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .stop_det    (stop_det),
    .sda_oe      (sda_oe),
    .st          (st_mon),
    .pb_commit   (pb_commit),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .ptr         (ptr_q)
);

// File: tb/sim_ee2w_slave.sv
module sim_ee2w_slave;
    localparam int H    = 20;
    localparam int Q    = 4;
    localparam int BUSY = 600;
    localparam int AW   = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, sda_bus, wr_busy;
    logic pb_wr_en, pb_commit, mem_rd_en;
    logic [AW-1:0] pb_wr_addr, mem_rd_addr;
    logic [7:0] pb_wr_data, rd_q;

    assign sda_bus = sda_m & ~sda_oe;

    ee2w_slave u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_oe      (sda_oe),
        .wr_busy_i   (wr_busy),
        .pb_wr_en    (pb_wr_en),
        .pb_wr_addr  (pb_wr_addr),
        .pb_wr_data  (pb_wr_data),
        .pb_commit   (pb_commit),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (rd_q)
    );

    // ---------------- memory, page buffer and sequencer model ----------------
    logic [7:0]    mem [0:2047];
    logic [AW-1:0] wl_a [0:63];
    logic [7:0]    wl_d [0:63];
    int wn = 0, cbase = 0, ncommit = 0, nrd = 0, busy_cnt = 0;
    int nchk = 0, nerr = 0, r12_viol = 0;
    logic oe_prev = 1'b0;
    logic done = 1'b0;

    function automatic logic [7:0] f_init(int a);
        return 8'((a * 37 + (a >> 3)) & 255);
    endfunction

    initial for (int i = 0; i < 2048; i++) mem[i] = f_init(i);

    assign wr_busy = (busy_cnt != 0);

    always @(posedge clk) begin
        if (mem_rd_en) begin
            rd_q <= mem[mem_rd_addr];
            nrd = nrd + 1;
        end
        if (pb_wr_en && wn < 64) begin
            wl_a[wn] = pb_wr_addr;
            wl_d[wn] = pb_wr_data;
            wn = wn + 1;
        end
        if (pb_commit) begin
            for (int k = cbase; k < wn; k++) mem[wl_a[k]] = wl_d[k];
            cbase = wn;
            ncommit = ncommit + 1;
            busy_cnt = BUSY;
        end else if (busy_cnt > 0) begin
            busy_cnt = busy_cnt - 1;
        end
    end

    // R12 monitor: the pull-down must not move while the clock line is high
    always @(negedge clk) begin
        if (rst_n && scl_m && sda_oe != oe_prev) r12_viol = r12_viol + 1;
        oe_prev = sda_oe;
    end

    // ---------------- helpers ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, int act, int exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nerr = nerr + 1;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic m_bit(logic v);
        sda_m = v;
        tick(H - Q);
        scl_m = 1'b1;
        tick(H);
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic m_start();
        sda_m = 1'b1;
        tick(H - Q);
        scl_m = 1'b1;
        tick(H);
        sda_m = 1'b0;
        tick(H);
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0;
        tick(H - Q);
        scl_m = 1'b1;
        tick(H);
        sda_m = 1'b1;
        tick(H);
    endtask

    task automatic m_send(logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) m_bit(b[i]);
        sda_m = 1'b1;
        tick(H - Q);
        scl_m = 1'b1;
        tick(H / 2);
        acked = !sda_bus;
        tick(H / 2);
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic m_recv(output logic [7:0] b, input logic mack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1;
            tick(H - Q);
            scl_m = 1'b1;
            tick(H / 2);
            b[i] = sda_bus;
            tick(H / 2);
            scl_m = 1'b0;
            tick(Q);
        end
        m_bit(!mack);
        sda_m = 1'b1;
    endtask

    task automatic wait_free();
        while (wr_busy) tick(1);
        tick(20);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check("R1 reset sda_oe", int'(sda_oe), 0);
        check("R1 reset commit", int'(pb_commit), 0);
        check("R1 reset rd_en", int'(mem_rd_en), 0);
    endtask

    task automatic t_bad_code();
        logic a;
        m_start();
        m_send(8'hB0, a);
        check("R2 foreign code nack", int'(a), 0);
        m_send(8'hA0, a);
        check("R2 ignored until START", int'(a), 0);
        m_stop();
        check("R1 idle after STOP", int'(sda_oe), 0);
    endtask

    task automatic t_byte_write();
        logic a;
        int w0 = wn, c0 = ncommit;
        m_start();
        m_send(8'hAA, a); check("R4 ctrl ack", int'(a), 1);
        m_send(8'h3C, a); check("R4 addr ack", int'(a), 1);
        m_send(8'h5A, a); check("R4 data ack", int'(a), 1);
        m_stop();
        tick(10);
        check("R4 write count", wn - w0, 1);
        check("R4 write addr", int'(wl_a[w0]), 'h53C);
        check("R4 write data", int'(wl_d[w0]), 'h5A);
        check("R6 commit after data", ncommit - c0, 1);
    endtask

    task automatic t_poll();
        logic a;
        int c0;
        check("R3 busy seen", int'(wr_busy), 1);
        m_start();
        m_send(8'hA0, a);
        check("R3 nack while busy", int'(a), 0);
        m_stop();
        wait_free();
        c0 = ncommit;
        m_start();
        m_send(8'hA0, a);
        check("R3 ack when free", int'(a), 1);
        m_stop();
        tick(10);
        check("R6 no commit without data", ncommit - c0, 0);
    endtask

    task automatic t_page_write();
        logic a;
        int w0, c0;
        wait_free();
        w0 = wn; c0 = ncommit;
        m_start();
        m_send(8'hA4, a);
        m_send(8'h2E, a);
        for (int i = 0; i < 18; i++) m_send(8'(8'h80 + i), a);
        m_stop();
        tick(10);
        check("R5 byte count", wn - w0, 18);
        for (int i = 0; i < 18; i++) begin
            check("R5 page addr", int'(wl_a[w0 + i]), 'h220 | ((14 + i) & 15));
            check("R4 page data", int'(wl_d[w0 + i]), 'h80 + i);
        end
        check("R6 page commit", ncommit - c0, 1);
    endtask

    task automatic t_cur_read();
        logic a;
        logic [7:0] b;
        wait_free();
        m_start();
        m_send(8'hA1, a);
        check("R8 read ctrl ack", int'(a), 1);
        m_recv(b, 1'b0);
        m_stop();
        check("R8 current-address byte", int'(b), 'h82);
    endtask

    task automatic t_rand_seq();
        logic a;
        logic [7:0] b0, b1, b2;
        int n0, lows = 0;
        m_start();
        m_send(8'hAE, a);
        m_send(8'hFE, a);
        m_start();
        m_send(8'hA1, a);
        check("R7 read ack", int'(a), 1);
        m_recv(b0, 1'b1);
        m_recv(b1, 1'b1);
        m_recv(b2, 1'b0);
        check("R7 random byte", int'(b0), int'(f_init('h7FE)));
        check("R9 next byte", int'(b1), int'(f_init('h7FF)));
        check("R9 wrap to 0", int'(b2), int'(f_init(0)));
        n0 = nrd;
        for (int i = 0; i < 9; i++) begin
            sda_m = 1'b1;
            tick(H - Q);
            scl_m = 1'b1;
            tick(H / 2);
            if (!sda_bus) lows++;
            tick(H / 2);
            scl_m = 1'b0;
            tick(Q);
        end
        check("R10 line released", lows, 0);
        check("R10 no fetch", nrd - n0, 0);
        m_stop();
    endtask

    task automatic t_abort();
        logic a;
        logic [7:0] b;
        int c0 = ncommit;
        m_start();
        m_send(8'hA0, a);
        m_send(8'h10, a);
        m_send(8'h33, a);
        m_start();
        m_send(8'hA1, a);
        m_recv(b, 1'b0);
        m_stop();
        tick(10);
        check("R6 repeated START cancels commit", ncommit - c0, 0);
        check("R6 pointer kept", int'(b), int'(f_init('h011)));
        m_start();
        m_send(8'hA0, a);
        m_bit(1'b1); m_bit(1'b1); m_bit(1'b1);
        m_start();
        m_send(8'hA1, a);
        check("R11 fresh ctrl ack", int'(a), 1);
        m_recv(b, 1'b0);
        m_stop();
        check("R11 read after abort", int'(b), int'(f_init('h012)));
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_bad_code();
        t_byte_write();
        t_poll();
        t_page_write();
        t_cur_read();
        t_rand_seq();
        t_abort();
        tick(10);
        check("R1 idle at end", int'(sda_oe), 0);
        check("R12 oe stable while clock high", r12_viol, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk = nchk + 1;
            nerr = nerr + 1;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule